// File: doc/BRIEF.md
# Two-Step Orthogonal Response Compactor

This block shrinks a wide functional response from a core under test down to a narrow signature, and it does so without losing any error that the stored test set can produce. Each pattern's response is first latched into a hold register. In the first step, a fixed group of Q response bits goes straight to the output, with no logic on the path. In the second step, a comparator bank looks for the held response in the table of known-good responses. A match gives a nonzero code naming the response's place inside its first-step group. No match gives zero. A Q-bit two-way multiplexer picks which of the two paths reaches `sig_out`.

The good responses are placed so that any two that share a first-step group receive different second-step codes. As a result, the pair of codes is unique for every good response. A pattern whose first-step group holds only that one good response does not need the second step. A skip table, filled in at elaboration, sends such patterns straight back to idle.

The test controller pulses `start` once per pattern, together with the pattern number and the core response. It then reads one or two valid signature beats, tagged by `step`. The beat that ends the pattern carries `done`.

Top module: `two_step_compactor`

## Requirements
- R1: After reset, and at any time no pattern is in progress, `out_valid`, `step`, `done` and `sig_out` are all 0.
- R2: When the controller is idle and `start` is sampled high, `core_resp` and `pat_idx` are latched on that edge. The following cycle is a capture cycle with `out_valid` low. The first-step beat appears in the cycle after that.
- R3: During the first-step beat, `out_valid`=1, `step`=0, and `sig_out` equals bits [Q-1:0] of the latched response.
- R4: Good response i, for i from 0 to N_RESP-1, has bits [Q-1:0] = i / (2^Q-1) and bits [N_IN-1:Q] = the low bits of i*SALT. During the second-step beat, `out_valid`=1, `step`=1, and a held response equal to good response i gives `sig_out` = (i mod (2^Q-1)) + 1.
- R5: A held response that matches no good response gives `sig_out`=0 in the second-step beat.
- R6: Across all good responses that take both steps, the pair (first-step code, second-step code) is unique and the second-step code is never 0.
- R7: Pattern number p skips the second step exactly when no other good response shares the first-step group p / (2^Q-1). A skipped pattern returns to idle directly after its first-step beat. With the defaults, only pattern 9 skips.
- R8: `done` is high for exactly one cycle per pattern, on the last valid beat of that pattern: the second-step beat, or the first-step beat when the pattern skips.
- R9: A `start` that arrives while a pattern is in progress is ignored. The beats that follow belong only to the pattern already in progress.
- R10: For every non-skipped good response, flipping any single bit changes at least one of the two codes.
- R11: Changes on `core_resp` after the latch edge have no effect on either beat of the pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin compaction of one pattern |
| pat_idx | input | PW | Pattern number, used to look up the skip table |
| core_resp | input | N_IN | Functional response of the core under test |
| sig_out | output | Q | Compacted signature beat |
| out_valid | output | 1 | A signature beat is present |
| step | output | 1 | 0 = feed-through beat, 1 = orthogonal-map beat |
| done | output | 1 | Last beat of the current pattern |

## Verification
The hardest situations to reach are the ones where stimulus lands while the controller is busy. These are a second `start` that arrives during capture and during the first step, and a response bus that changes right after the latch edge. The bench holds `start` high across the whole pattern, with a different pattern number and response on the inputs. It also drives the inverse response on `core_resp` during every run, so any path that leaks the live bus shows up in the codes. The error-detection sweep applies all 32 single-bit flips to every non-skipped good response, and compares the code pair it gets against the pair that response gives when it is error-free.

// File: rtl/csc_pkg.sv
package csc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_STEP1   = 2'd2,
        ST_STEP2   = 2'd3
    } csc_state_e;

    // Good response number idx: group id in the low q bits,
    // a bijective scramble of idx above them.
    function automatic logic [63:0] ref_resp(input int unsigned idx,
                                             input int unsigned q,
                                             input logic [63:0] salt);
        logic [63:0] prod;
        prod = 64'(idx) * salt;
        return (prod << q) | 64'(idx / ((32'd1 << q) - 32'd1));
    endfunction

endpackage

// File: rtl/csc_ortho_map.sv
module csc_ortho_map #(
    parameter int          N_IN   = 32,
    parameter int          Q      = 2,
    parameter int          N_RESP = 10,
    parameter logic [31:0] SALT   = 32'h9E3779B1
) (
    input  logic [N_IN-1:0]   resp,
    output logic [Q-1:0]      code,
    output logic [N_RESP-1:0] hit
);
    localparam int CAP = (1 << Q) - 1;

    logic [Q-1:0] part [N_RESP];

    for (genvar i = 0; i < N_RESP; i++) begin : g_entry
        localparam logic [N_IN-1:0] REF  = N_IN'(csc_pkg::ref_resp(i, Q, 64'(SALT)));
        localparam logic [Q-1:0]    CODE = Q'((i % CAP) + 1);
        assign hit[i]  = (resp == REF);
        assign part[i] = hit[i] ? CODE : '0;
    end

    always_comb begin
        code = '0;
        for (int k = 0; k < N_RESP; k++) begin
            code = code | part[k];
        end
    end
endmodule

// File: rtl/csc_skip_table.sv
module csc_skip_table #(
    parameter int N_RESP = 10,
    parameter int Q      = 2,
    parameter int PW     = 4
) (
    input  logic [PW-1:0] idx,
    output logic          skip
);
    localparam int CAP   = (1 << Q) - 1;
    localparam int DEPTH = 1 << PW;

    function automatic logic [DEPTH-1:0] build_skip();
        logic [DEPTH-1:0] bits;
        bits = '0;
        for (int p = 0; p < N_RESP; p++) begin
            int members;
            members = 0;
            for (int j = 0; j < N_RESP; j++) begin
                if (j / CAP == p / CAP) members++;
            end
            bits[p] = (members == 1);
        end
        return bits;
    endfunction

    localparam logic [DEPTH-1:0] SKIP_BITS = build_skip();

    assign skip = SKIP_BITS[idx];
endmodule

// File: rtl/csc_out_mux.sv
module csc_out_mux #(
    parameter int W = 2
) (
    input  logic         sel,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic [W-1:0] y
);
    assign y = sel ? in_b : in_a;
endmodule

// File: rtl/csc_ctrl.sv
module csc_ctrl
    import csc_pkg::*;
#(
    parameter int N_IN = 32,
    parameter int PW   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [PW-1:0]   pat_idx,
    input  logic [N_IN-1:0] core_resp,
    input  logic            skip,
    output csc_state_e      state,
    output logic [N_IN-1:0] hold,
    output logic [PW-1:0]   idx
);
    typedef struct packed {
        csc_state_e      state;
        logic [N_IN-1:0] hold;
        logic [PW-1:0]   idx;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (start) begin
                    ctrl_d.state = ST_CAPTURE;
                    ctrl_d.hold  = core_resp;
                    ctrl_d.idx   = pat_idx;
                end
            end
            ST_CAPTURE: ctrl_d.state = ST_STEP1;
            ST_STEP1:   ctrl_d.state = skip ? ST_IDLE : ST_STEP2;
            ST_STEP2:   ctrl_d.state = ST_IDLE;
            default:    ctrl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{state: ST_IDLE, hold: '0, idx: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign state = ctrl_q.state;
    assign hold  = ctrl_q.hold;
    assign idx   = ctrl_q.idx;

    // R2: one capture cycle, then the feed-through step
    a_r2_capture_then_step1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_CAPTURE) |=> (ctrl_q.state == ST_STEP1));
    // R7: skipped pattern goes straight back to idle
    a_r7_skip_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_STEP1 && skip) |=> (ctrl_q.state == ST_IDLE));
    // R9, R11: the held response does not move while busy
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state != ST_IDLE) |=> $stable(ctrl_q.hold));
endmodule

// File: rtl/two_step_compactor.sv
module two_step_compactor
    import csc_pkg::*;
#(
    parameter int          N_IN   = 32,
    parameter int          Q      = 2,
    parameter int          N_RESP = 10,
    parameter logic [31:0] SALT   = 32'h9E3779B1,
    parameter int          PW     = (N_RESP > 1) ? $clog2(N_RESP) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [PW-1:0]   pat_idx,
    input  logic [N_IN-1:0] core_resp,
    output logic [Q-1:0]    sig_out,
    output logic            out_valid,
    output logic            step,
    output logic            done
);
    csc_state_e        state;
    logic [N_IN-1:0]   hold;
    logic [PW-1:0]     idx;
    logic              skip;
    logic [Q-1:0]      ortho_code;
    logic [N_RESP-1:0] hit;
    logic [Q-1:0]      mux_y;

    csc_ctrl #(.N_IN(N_IN), .PW(PW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .pat_idx(pat_idx),
        .core_resp(core_resp), .skip(skip),
        .state(state), .hold(hold), .idx(idx)
    );

    csc_skip_table #(.N_RESP(N_RESP), .Q(Q), .PW(PW)) u_skip (
        .idx(idx), .skip(skip)
    );

    csc_ortho_map #(.N_IN(N_IN), .Q(Q), .N_RESP(N_RESP), .SALT(SALT)) u_map (
        .resp(hold), .code(ortho_code), .hit(hit)
    );

    csc_out_mux #(.W(Q)) u_mux (
        .sel(step), .in_a(hold[Q-1:0]), .in_b(ortho_code), .y(mux_y)
    );

    assign out_valid = (state == ST_STEP1) || (state == ST_STEP2);
    assign step      = (state == ST_STEP2);
    assign done      = (state == ST_STEP2) || ((state == ST_STEP1) && skip);
    assign sig_out   = out_valid ? mux_y : '0;

    // R6: good responses are distinct, so at most one entry matches
    a_r6_one_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
    // R8: done only ever rides on a valid beat
    a_r8_done_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> out_valid);
    // R3, R4: a second-step beat always follows a first-step beat
    a_r4_step2_after_step1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(step) |-> ($past(out_valid) && !$past(step)));
endmodule

// File: tb/two_step_compactor_bench.sv
`timescale 1ns/1ps
module two_step_compactor_bench;
    localparam int          N_IN = 32;
    localparam int          Q    = 2;
    localparam int          NR   = 10;
    localparam logic [31:0] SALT = 32'h9E3779B1;
    localparam int          PW   = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [PW-1:0]   pat_idx = '0;
    logic [N_IN-1:0] core_resp = '0;
    logic [Q-1:0]    sig_out;
    logic            out_valid, step, done;

    always #2 clk = ~clk;

    two_step_compactor #(.N_IN(N_IN), .Q(Q), .N_RESP(NR), .SALT(SALT), .PW(PW))
        u_two_step_compactor (
        .clk(clk), .rst_n(rst_n), .start(start), .pat_idx(pat_idx),
        .core_resp(core_resp), .sig_out(sig_out), .out_valid(out_valid),
        .step(step), .done(done));

    typedef struct {
        logic [Q-1:0] sig;
        logic         stp;
        logic         dn;
        string        req;
    } exp_t;

    exp_t exp_q[$];
    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [Q-1:0] last_s1, last_s2;
    bit got2;

    function automatic logic [N_IN-1:0] golden(input int i);
        logic [31:0] m;
        m = 32'(i) * SALT;
        return {m[N_IN-Q-1:0], Q'(i / 3)};
    endfunction

    function automatic logic [Q-1:0] model_code(input logic [N_IN-1:0] r);
        for (int i = 0; i < NR; i++) if (r == golden(i)) return Q'((i % 3) + 1);
        return '0;
    endfunction

    function automatic bit model_skip(input int p);
        int n;
        n = 0;
        if (p >= NR) return 0;
        for (int j = 0; j < NR; j++) if (j / 3 == p / 3) n++;
        return n == 1;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic push_expect(input int idx, input logic [N_IN-1:0] r, input string req);
        exp_t e;
        bit sk;
        sk = model_skip(idx);
        e.sig = r[Q-1:0]; e.stp = 1'b0; e.dn = sk; e.req = {req, "/R3/R8/R11"};
        exp_q.push_back(e);
        if (!sk) begin
            e.sig = model_code(r); e.stp = 1'b1; e.dn = 1'b1; e.req = {req, "/R4/R5/R8/R11"};
            exp_q.push_back(e);
        end
    endtask

    task automatic run_pat(input int idx, input logic [N_IN-1:0] r, input string req);
        push_expect(idx, r, req);
        @(negedge clk);
        start = 1'b1; pat_idx = PW'(idx); core_resp = r;
        @(negedge clk);
        start = 1'b0; core_resp = ~r;          // R11: bus moves after the latch
        check(out_valid == 1'b0, "R2 capture cycle", 64'(out_valid), 64'(0));
        repeat (4) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected beat", 64'(sig_out), 64'(0));
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(sig_out == e.sig && step == e.stp && done == e.dn, e.req,
                          {61'(sig_out), step, done}, {61'(e.sig), e.stp, e.dn});
                end
                if (!step) begin last_s1 = sig_out; got2 = 0; end
                else begin last_s2 = sig_out; got2 = 1; end
            end else if (done || step || sig_out != '0) begin
                check(1'b0, "R1 idle outputs", {61'(sig_out), step, done}, 64'(0));
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
    end

    initial begin
        logic [Q-1:0] s1 [NR];
        logic [Q-1:0] s2 [NR];
        bit           two [NR];

        repeat (3) @(negedge clk);
        check(out_valid == 0 && step == 0 && done == 0 && sig_out == 0, "R1 reset",
              {60'(sig_out), out_valid, step, done}, 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 0 && sig_out == 0, "R1 after reset",
              {62'(sig_out), out_valid, 1'b0}, 64'(0));

        // R3 R4 R7: every good response
        for (int i = 0; i < NR; i++) begin
            run_pat(i, golden(i), "R4 good");
            s1[i] = last_s1; s2[i] = last_s2; two[i] = got2;
            check(two[i] == !model_skip(i), "R7 skip decision", 64'(two[i]),
                  64'(!model_skip(i)));
        end
        check(two[9] == 0, "R7 pattern 9 skipped", 64'(two[9]), 64'(0));

        // R6: code pairs unique and nonzero
        for (int i = 0; i < NR; i++) begin
            if (two[i]) begin
                check(s2[i] != '0, "R6 nonzero code", 64'(s2[i]), 64'(1));
                for (int j = i + 1; j < NR; j++) begin
                    if (two[j])
                        check({s1[i], s2[i]} != {s1[j], s2[j]}, "R6 unique pair",
                              64'({s1[j], s2[j]}), 64'({s1[i], s2[i]}));
                end
            end
        end

        // R5: unknown response maps to zero
        run_pat(0, 32'h1234_5678, "R5 unknown");
        check(last_s2 == '0 && got2, "R5 zero code", 64'(last_s2), 64'(0));

        // R9: start held high through a busy pattern with other inputs
        push_expect(1, golden(1), "R9 busy start");
        @(negedge clk);
        start = 1'b1; pat_idx = PW'(1); core_resp = golden(1);
        @(negedge clk);
        pat_idx = PW'(9); core_resp = golden(5);
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        check(last_s1 == s1[1] && last_s2 == s2[1], "R9 kept first pattern",
              64'({last_s1, last_s2}), 64'({s1[1], s2[1]}));

        // R10: every single-bit error on non-skipped responses is seen
        for (int i = 0; i < NR; i++) begin
            if (!model_skip(i)) begin
                for (int b = 0; b < N_IN; b++) begin
                    logic [N_IN-1:0] flip;
                    flip = golden(i) ^ (N_IN'(1) << b);
                    run_pat(i, flip, "R10 flip");
                    check({last_s1, last_s2} != {s1[i], s2[i]}, "R10 error seen",
                          64'({last_s1, last_s2}), 64'({s1[i], s2[i]}));
                end
            end
        end

        check(exp_q.size() == 0, "R8 all beats seen", 64'(exp_q.size()), 64'(0));
        summary();
    end
endmodule